// File: doc/BRIEF.md
# External Interrupt Pin Sense Unit

This block turns a row of asynchronous external interrupt pins into one active-high level request per pin for a parent interrupt controller. Each pin is first brought into the clock domain through a synchroniser. Its sense mode is chosen by a two-bit field in a packed configuration register. The modes are low level, falling edge, rising edge and both edges.

In an edge mode the detected event is held in a status bit, and that bit drives the request until software clears it. Software clears a status bit by writing zero to it. In low-level mode the status bit shows the inverted pin and cannot be cleared. A mask register can block any request. The status bit keeps latching events while its pin is masked.

Software reaches the configuration, status and mask registers through a simple 32-bit port. The port has a write strobe and a combinational read. A write lands on the clock edge at which the strobe is sampled. A read that follows shows the updated state, so a cleared event is never seen as pending again.

Top module: `xirq_sense_unit`

## Requirements
- R1: After reset the configuration, status and mask registers read as zero. With all pins held high, every request output is low.
- R2: The configuration register is at offset 0x14 and holds two bits per pin, with pin n at bits [2n+1:2n]. The code values are 0 = low level, 1 = falling edge, 2 = rising edge and 3 = both edges. Bits above 2*N_PINS read as zero.
- R3: In low-level mode (code 0), the request is high exactly while the synchronised pin is low and unmasked. Status bit n reads as the inverted synchronised pin. Writing zero to that status bit has no effect.
- R4: In falling-edge mode (code 1), a high-to-low transition sets status bit n. A low-to-high transition does not set it.
- R5: In rising-edge mode (code 2), a low-to-high transition sets status bit n. A high-to-low transition does not set it.
- R6: In both-edge mode (code 3), any transition sets status bit n.
- R7: The status register is at offset 0x10. Writing 0 to bit n clears that bit when pin n is in an edge mode. Writing 1 leaves it unchanged. A read in the cycle after the clearing write returns the cleared value.
- R8: When an edge event and a clearing write for the same pin fall on the same clock edge, the status bit stays set.
- R9: The mask register is at offset 0x10010, with bit n for pin n. A 1 forces request n low and a 0 lets it through. Masking does not stop status bits from latching. Bits above N_PINS read as zero.
- R10: A pin change reaches a level-mode request on the second rising clock edge after the change, through the two-flop synchroniser.
- R11: In an edge mode, the request is a level. It stays high for as long as the status bit is set and the pin is unmasked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_PINS | Asynchronous external interrupt pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr (combinational) |
| irq_o | output | N_PINS | Active-high level requests to the parent controller |

## Verification
The hardest case to reach is an edge event that lands on the same clock edge as a software clear of the same status bit. The edge only shows up after the synchroniser and the edge-detect stage, so the bench counts those stages. It toggles the pin and lets two clock edges pass, then issues the clearing write so that it is sampled in the cycle in which the detector fires. A reference model that updates on every edge confirms the alignment. A second hard case is a zero written to a pin in low-level mode. The bench checks that this write leaves both the status read-back and the request unchanged.

// File: rtl/xis_pkg.sv
package xis_pkg;
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'd0,
      SENSE_FALL = 2'd1,
      SENSE_RISE = 2'd2,
      SENSE_BOTH = 2'd3
   } sense_e;

   function automatic logic sense_is_edge(sense_e m);
      return m != SENSE_LOW;
   endfunction
endpackage

// File: rtl/xis_sync.sv
module xis_sync #(
   parameter int N_PINS      = 8,
   parameter int STAGES      = 2,
   parameter bit IDLE_LEVEL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pin_i,
   output logic [N_PINS-1:0] pin_now,
   output logic [N_PINS-1:0] pin_prev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xis_sync: STAGES must be at least 2");
   end

   for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      logic [STAGES-1:0] chain_q;
      logic              prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= {STAGES{IDLE_LEVEL}};
            prev_q  <= IDLE_LEVEL;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i[p]};
            prev_q  <= chain_q[STAGES-1];
         end
      end
      assign pin_now[p]  = chain_q[STAGES-1];
      assign pin_prev[p] = prev_q;
   end
endmodule

// File: rtl/xis_channel.sv
module xis_channel
   import xis_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pin_now,
   input  logic   pin_prev,
   input  sense_e mode,
   input  logic   clr_wr,
   input  logic   mask,
   output logic   stat_q,
   output logic   edge_ev,
   output logic   clr_req,
   output logic   irq,
   output logic   rd_bit
);
   always_comb begin
      unique case (mode)
         SENSE_FALL: edge_ev = pin_prev & ~pin_now;
         SENSE_RISE: edge_ev = ~pin_prev & pin_now;
         SENSE_BOTH: edge_ev = pin_prev ^ pin_now;
         default:    edge_ev = 1'b0;
      endcase
   end

   assign clr_req = clr_wr & stat_q & sense_is_edge(mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   stat_q <= 1'b0;
      else if (!sense_is_edge(mode)) stat_q <= 1'b0;
      else                          stat_q <= edge_ev | (stat_q & ~clr_wr);
   end

   assign irq    = sense_is_edge(mode) ? (stat_q & ~mask) : (~pin_now & ~mask);
   assign rd_bit = sense_is_edge(mode) ? stat_q : ~pin_now;
endmodule

// File: rtl/xirq_sense_unit.sv
module xirq_sense_unit
   import xis_pkg::*;
#(
   parameter int                N_PINS      = 8,
   parameter int                ADDR_W      = 20,
   parameter int                DATA_W      = 32,
   parameter int                SYNC_STAGES = 2,
   parameter bit                PIN_IDLE    = 1'b1,
   parameter logic [ADDR_W-1:0] STAT_OFS    = 'h00010,
   parameter logic [ADDR_W-1:0] CFG_OFS     = 'h00014,
   parameter logic [ADDR_W-1:0] MASK_OFS    = 'h10010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pin_i,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [N_PINS-1:0] irq_o
);
   localparam int CFG_W = 2 * N_PINS;

   if (N_PINS < 1 || CFG_W > DATA_W) begin : g_bad_width
      $error("xirq_sense_unit: 2*N_PINS must fit in DATA_W");
   end
   if (STAT_OFS == CFG_OFS || STAT_OFS == MASK_OFS || CFG_OFS == MASK_OFS) begin : g_bad_map
      $error("xirq_sense_unit: register offsets must differ");
   end

   logic [CFG_W-1:0]  cfg_q;
   logic [N_PINS-1:0] mask_q;
   logic [N_PINS-1:0] pin_now, pin_prev;
   logic [N_PINS-1:0] stat_q, edge_ev, clr_req, clr_wr, rd_stat, is_edge;

   logic wr_cfg, wr_mask, wr_stat;
   assign wr_cfg  = reg_wr && (reg_addr == CFG_OFS);
   assign wr_mask = reg_wr && (reg_addr == MASK_OFS);
   assign wr_stat = reg_wr && (reg_addr == STAT_OFS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         mask_q <= '0;
      end else begin
         if (wr_cfg)  cfg_q  <= reg_wdata[CFG_W-1:0];
         if (wr_mask) mask_q <= reg_wdata[N_PINS-1:0];
      end
   end

   xis_sync #(
      .N_PINS     (N_PINS),
      .STAGES     (SYNC_STAGES),
      .IDLE_LEVEL (PIN_IDLE)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (pin_i),
      .pin_now  (pin_now),
      .pin_prev (pin_prev)
   );

   for (genvar i = 0; i < N_PINS; i++) begin : g_chan
      sense_e mode_w;
      assign mode_w     = sense_e'(cfg_q[2*i +: 2]);
      assign clr_wr[i]  = wr_stat & ~reg_wdata[i];
      assign is_edge[i] = sense_is_edge(mode_w);

      xis_channel u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin_now  (pin_now[i]),
         .pin_prev (pin_prev[i]),
         .mode     (mode_w),
         .clr_wr   (clr_wr[i]),
         .mask     (mask_q[i]),
         .stat_q   (stat_q[i]),
         .edge_ev  (edge_ev[i]),
         .clr_req  (clr_req[i]),
         .irq      (irq_o[i]),
         .rd_bit   (rd_stat[i])
      );
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == STAT_OFS)      reg_rdata[N_PINS-1:0] = rd_stat;
      else if (reg_addr == CFG_OFS)  reg_rdata[CFG_W-1:0]  = cfg_q;
      else if (reg_addr == MASK_OFS) reg_rdata[N_PINS-1:0] = mask_q;
   end
endmodule

// File: rtl/xirq_sense_unit_chk.sv
module xirq_sense_unit_chk #(
   parameter int N_PINS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_PINS-1:0] irq_o,
   input logic [N_PINS-1:0] mask_q,
   input logic [N_PINS-1:0] is_edge,
   input logic [N_PINS-1:0] stat_q,
   input logic [N_PINS-1:0] edge_ev,
   input logic [N_PINS-1:0] clr_req,
   input logic [N_PINS-1:0] pin_now
);
   for (genvar i = 0; i < N_PINS; i++) begin : g_bit
      assert_masked_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
         mask_q[i] |-> !irq_o[i]);
      assert_level_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (is_edge[i] && stat_q[i] && !mask_q[i]) |-> irq_o[i]);
      assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!is_edge[i] && !mask_q[i]) |-> (irq_o[i] == !pin_now[i]));
      assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (is_edge[i] && edge_ev[i]) |=> stat_q[i]);
      assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_req[i] && !edge_ev[i]) |=> !stat_q[i]);
      assert_no_latch_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !is_edge[i] |=> !stat_q[i]);
   end
endmodule

bind xirq_sense_unit xirq_sense_unit_chk #(.N_PINS(N_PINS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_o   (irq_o),
   .mask_q  (mask_q),
   .is_edge (is_edge),
   .stat_q  (stat_q),
   .edge_ev (edge_ev),
   .clr_req (clr_req),
   .pin_now (pin_now)
);

// File: tb/xirq_sense_unit_bench.sv
module xirq_sense_unit_bench;
   localparam int PER = 10;
   localparam int N   = 8;
   localparam logic [19:0] A_STAT = 20'h00010;
   localparam logic [19:0] A_CFG  = 20'h00014;
   localparam logic [19:0] A_MASK = 20'h10010;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin_i = '1;
   logic          reg_wr = 1'b0;
   logic [19:0]   reg_addr = A_STAT;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [N-1:0]  irq_o;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   always #(PER/2) clk = ~clk;

   xirq_sense_unit u_xirq_sense_unit (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_o(irq_o)
   );

   // behavioural reference model
   bit [N-1:0] m_s1, m_s2, m_prev, m_st, m_mask;
   bit [15:0]  m_cfg;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '1; m_s2 <= '1; m_prev <= '1;
         m_st <= '0; m_mask <= '0; m_cfg <= '0;
      end else begin
         m_s1 <= pin_i; m_s2 <= m_s1; m_prev <= m_s2;
         for (int i = 0; i < N; i++) begin
            int  md;
            bit  ev, clr;
            md  = int'(m_cfg[2*i +: 2]);
            ev  = (md == 1 && m_prev[i] && !m_s2[i]) ||
                  (md == 2 && !m_prev[i] && m_s2[i]) ||
                  (md == 3 && m_prev[i] != m_s2[i]);
            clr = reg_wr && reg_addr == A_STAT && !reg_wdata[i];
            if (md == 0) m_st[i] <= 1'b0;
            else         m_st[i] <= ev || (m_st[i] && !clr);
         end
         if (reg_wr && reg_addr == A_CFG)  m_cfg  <= reg_wdata[15:0];
         if (reg_wr && reg_addr == A_MASK) m_mask <= reg_wdata[N-1:0];
      end
   end

   function automatic bit [N-1:0] exp_irq();
      bit [N-1:0] r;
      for (int i = 0; i < N; i++)
         r[i] = (m_cfg[2*i +: 2] == 2'd0) ? (!m_s2[i] && !m_mask[i]) : (m_st[i] && !m_mask[i]);
      return r;
   endfunction

   function automatic bit [N-1:0] exp_stat();
      bit [N-1:0] r;
      for (int i = 0; i < N; i++)
         r[i] = (m_cfg[2*i +: 2] == 2'd0) ? !m_s2[i] : m_st[i];
      return r;
   endfunction

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (irq_o !== exp_irq()) begin
            errors++;
            $display("FAIL %s irq_o actual %h expected %h", cur_req, irq_o, exp_irq());
         end
         if (!reg_wr && reg_addr == A_STAT) begin
            checks++;
            if (reg_rdata[N-1:0] !== exp_stat()) begin
               errors++;
               $display("FAIL %s status actual %h expected %h", cur_req, reg_rdata[N-1:0], exp_stat());
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #(PER/4);
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) tick();
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [19:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_wr = 1'b0; reg_addr = A_STAT;
   endtask

   task automatic rd(input string tag, input logic [19:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
      reg_addr = A_STAT;
   endtask

   initial begin
      ticks(3);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      cur_req = "R1";
      chk("R1 irq", {24'd0, irq_o}, 32'd0);
      rd("R1 cfg", A_CFG, 32'd0);
      rd("R1 mask", A_MASK, 32'd0);
      rd("R1 status", A_STAT, 32'd0);

      // R2 packed modes: pins 0..3 and 4..7 = low, fall, rise, both
      cur_req = "R2";
      wr(A_CFG, 32'hFFFF_E4E4);
      rd("R2 cfg readback", A_CFG, 32'h0000_E4E4);
      ticks(2);

      // R10 / R3 level mode latency and behaviour
      cur_req = "R10";
      pin_i[0] = 1'b0;
      tick();
      chk("R10 irq0 after one edge", {31'd0, irq_o[0]}, 32'd0);
      tick();
      chk("R10 irq0 after two edges", {31'd0, irq_o[0]}, 32'd1);
      cur_req = "R3";
      wr(A_STAT, 32'h0);
      rd("R3 status unaffected by clear", A_STAT, 32'h0000_0001);
      chk("R3 irq0 still high", {31'd0, irq_o[0]}, 32'd1);
      pin_i[0] = 1'b1;
      ticks(3);
      chk("R3 irq0 released", {31'd0, irq_o[0]}, 32'd0);

      // R4 falling edge on pin1
      cur_req = "R4";
      pin_i[1] = 1'b0;
      ticks(4);
      rd("R4 fall latched", A_STAT, 32'h0000_0002);
      cur_req = "R11";
      pin_i[1] = 1'b1;
      ticks(5);
      chk("R11 irq1 held", {31'd0, irq_o[1]}, 32'd1);

      // R5 rising edge on pin2
      cur_req = "R5";
      pin_i[2] = 1'b0;
      ticks(4);
      rd("R5 fall ignored", A_STAT, 32'h0000_0002);
      pin_i[2] = 1'b1;
      ticks(4);
      rd("R5 rise latched", A_STAT, 32'h0000_0006);

      // R6 both edges on pin3, with clear in between (R7)
      cur_req = "R6";
      pin_i[3] = 1'b0;
      ticks(4);
      rd("R6 fall latched", A_STAT, 32'h0000_000E);
      cur_req = "R7";
      wr(A_STAT, ~32'h8);
      rd("R7 cleared readback", A_STAT, 32'h0000_0006);
      cur_req = "R6";
      pin_i[3] = 1'b1;
      ticks(4);
      rd("R6 rise latched", A_STAT, 32'h0000_000E);

      // R7 write of ones has no effect, zero clears
      cur_req = "R7";
      wr(A_STAT, 32'hFFFF_FFFF);
      rd("R7 ones keep", A_STAT, 32'h0000_000E);
      wr(A_STAT, ~32'h2);
      rd("R7 bit1 cleared", A_STAT, 32'h0000_000C);
      chk("R7 irq1 dropped", {31'd0, irq_o[1]}, 32'd0);

      // R8 edge coincident with clear on pin3
      cur_req = "R8";
      pin_i[3] = 1'b0;
      ticks(2);
      wr(A_STAT, ~32'h8);
      rd("R8 edge wins over clear", A_STAT, 32'h0000_000C);
      wr(A_STAT, ~32'h8);
      rd("R8 later clear takes", A_STAT, 32'h0000_0004);

      // R9 mask
      cur_req = "R9";
      wr(A_MASK, 32'hFFFF_FFFF);
      rd("R9 mask readback", A_MASK, 32'h0000_00FF);
      tick();
      chk("R9 all masked", {24'd0, irq_o}, 32'd0);
      pin_i[5] = 1'b0;
      ticks(4);
      rd("R9 latch while masked", A_STAT, 32'h0000_0024);
      chk("R9 irq5 masked", {31'd0, irq_o[5]}, 32'd0);
      wr(A_MASK, 32'h0);
      chk("R9 irq5 unmasked", {31'd0, irq_o[5]}, 32'd1);
      ticks(4);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(PER * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule